// File: doc/BRIEF.md
# Stereo Coarse/Fine Digital Volume Stage

This block scales a stereo PCM sample pair with a hardware volume setting held in one 16-bit register. Each channel owns a 4-bit fine field that adds gain in half-decibel steps, from 0 dB up to +5.5 dB. It also owns a 4-bit coarse field that attenuates in 6 dB steps. The two channels are fully independent. The fine gain is a multiply by a constant from a small coefficient table. The coarse attenuation is an arithmetic right shift by the coarse code.

A pair enters with a valid strobe and leaves two cycles later with its own valid strobe. The output cannot stall the pipeline, so a new pair may enter on every cycle. Software writes the register through a simple write strobe and can read it back at any time. Each pair takes the register value that was in place when the pair was accepted. A pair is therefore never scaled with a mix of old and new settings.

Top module: `stvol_top`

## Requirements
- R1: In reset, synchronous and active low, the volume register becomes 0x0000 (unity gain on both channels), out_valid goes low, and both output samples go to 0.
- R2: While vol_wr is high at a rising edge, vol_wdata is stored. It appears on vol_rdata from the next cycle. Without vol_wr the stored value does not change.
- R3: The register bits are laid out as follows. Left fine is bits 15:12 and left coarse is bits 11:8. Right fine is bits 7:4 and right coarse is bits 3:0. Each channel's result depends only on its own sample and its own two fields.
- R4: Fine code k (0..11) multiplies the sample by G(k)/32768, where G(k) = round(32768·10^(k/40)). Fine codes 12..15 behave as code 11. Fine code 0 with coarse code 0 passes the sample through unchanged.
- R5: The product sample·G is rounded to an integer as floor((sample·G + 16384) / 32768), which rounds halves toward plus infinity.
- R6: The rounded value is clamped to the range -32768..32767 before any shift. The output never has the opposite sign to the input.
- R7: The clamped value is shifted right arithmetically by the coarse code (0..15) of its channel. Coarse code 15 always yields 0 or -1.
- R8: out_valid is high exactly two cycles after in_valid was high, and low otherwise. Back-to-back pairs come out back to back. While out_valid is low, the output samples hold their last values.
- R9: A pair uses the register value held before the edge that accepts it. A write made in the same cycle as a pair affects only later pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vol_wr | input | 1 | Volume register write strobe |
| vol_wdata | input | 16 | Volume register write data |
| vol_rdata | output | 16 | Volume register read data |
| in_valid | input | 1 | Input pair valid |
| in_left | input | 16 | Left input sample, two's complement |
| in_right | input | 16 | Right input sample, two's complement |
| out_valid | output | 1 | Output pair valid |
| out_left | output | 16 | Scaled left sample, two's complement |
| out_right | output | 16 | Scaled right sample, two's complement |

## Verification
Several properties are checked on every cycle:
- the two-cycle valid latency, and that out_valid has no other cause;
- register readback, and that the register holds between writes;
- that the output holds when no pair is being delivered;
- that the output sign matches the input sign;
- the pass-through at unity, and the 0-or-minus-one floor at the deepest coarse step.

The exact coefficient values, the rounding direction and the clamp limits can only be shown by the bench's scenarios. The same holds for the field-to-channel mapping, the clamping of fine codes above 11, and the register timing at the sample boundary. Each scenario compares against values computed from the gain formula.

// File: rtl/stvol_pkg.sv
// Package: shared constants, the per-channel setting type and the fine
// gain coefficient lookup for the stereo volume stage.
// Assumes Q1.15 unsigned coefficients and 4-bit fine and coarse fields.
package stvol_pkg;

    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int FRAC_W   = 15;
    localparam int FIELD_W  = 4;
    localparam int NUM_CH   = 2;
    localparam int FINE_TOP = 11;
    localparam int CFG_W    = 2 * FIELD_W;
    localparam int REG_W    = NUM_CH * CFG_W;

    typedef struct packed {
        logic [FIELD_W-1:0] fine;
        logic [FIELD_W-1:0] coarse;
    } chan_cfg_t;

    // Fine code to Q1.15 multiplier, round(32768 * 10^(k/40)); codes above 11 clamp.
    function automatic logic [COEF_W-1:0] fine_coef(input logic [FIELD_W-1:0] code);
        logic [FIELD_W-1:0] k;
        k = (code > FIELD_W'(FINE_TOP)) ? FIELD_W'(FINE_TOP) : code;
        case (k)
            4'd0:    fine_coef = 16'd32768;
            4'd1:    fine_coef = 16'd34710;
            4'd2:    fine_coef = 16'd36766;
            4'd3:    fine_coef = 16'd38945;
            4'd4:    fine_coef = 16'd41252;
            4'd5:    fine_coef = 16'd43697;
            4'd6:    fine_coef = 16'd46286;
            4'd7:    fine_coef = 16'd49029;
            4'd8:    fine_coef = 16'd51934;
            4'd9:    fine_coef = 16'd55011;
            4'd10:   fine_coef = 16'd58271;
            default: fine_coef = 16'd61723;
        endcase
    endfunction

endpackage

// File: rtl/stvol_reg.sv
// Module: volume register with per-channel field decode.
// Holds the 16-bit setting word. Channel 0 (left) takes the upper byte and
// the last channel (right) takes the lowest byte; inside each byte the fine
// field sits above the coarse field. Assumes a single writer.
module stvol_reg
    import stvol_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [NCH*CFG_W-1:0]    wdata,
    output logic [NCH*CFG_W-1:0]    rdata,
    output chan_cfg_t               cfg [NCH]
);

    logic [NCH*CFG_W-1:0] vol_q;

    // Store the setting word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q <= '0;
        end else if (wr) begin
            vol_q <= wdata;
        end
    end

    assign rdata = vol_q;

    // Slice one byte per channel, first channel in the most significant byte.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_slice
        localparam int LSB = (NCH - 1 - ch) * CFG_W;
        assign cfg[ch] = chan_cfg_t'(vol_q[LSB +: CFG_W]);
    end

    // R2: a written word is read back on the next cycle
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata == $past(wdata)));

    // R2: without a write the stored word holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(rdata));

endmodule

// File: rtl/stvol_chan.sv
// Module: one channel of the volume datapath, two register stages.
// Stage 1 captures the sample with its coefficient and shift count.
// Stage 2 multiplies, rounds half up, clamps to the sample range and then
// shifts right arithmetically. Assumes that load2 follows load1 by one cycle.
module stvol_chan
    import stvol_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load1,
    input  logic                     load2,
    input  logic signed [DATA_W-1:0] in_sample,
    input  chan_cfg_t                cfg,
    output logic signed [DATA_W-1:0] out_sample
);

    localparam int PW = DATA_W + COEF_W + 1;
    localparam logic signed [PW-1:0] HALF =
        $signed({{(PW-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}});
    localparam logic signed [PW-1:0] SMAX =
        $signed({{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}});
    localparam logic signed [PW-1:0] SMIN =
        $signed({{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}});
    localparam logic [COEF_W-1:0] UNITY = fine_coef('0);

    logic signed [DATA_W-1:0] s1_sample;
    logic [COEF_W-1:0]        s1_coef;
    logic [FIELD_W-1:0]       s1_shift;
    logic signed [PW-1:0]     prod;
    logic signed [PW-1:0]     rnd;
    logic signed [DATA_W-1:0] sat;
    logic signed [DATA_W-1:0] scaled;

    // Stage 1: latch the sample together with the settings in force now.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_sample <= '0;
            s1_coef   <= '0;
            s1_shift  <= '0;
        end else if (load1) begin
            s1_sample <= in_sample;
            s1_coef   <= fine_coef(cfg.fine);
            s1_shift  <= cfg.coarse;
        end
    end

    // Multiply, round half toward plus infinity, clamp, then shift.
    always_comb begin
        prod = PW'(s1_sample) * $signed({{(PW-COEF_W){1'b0}}, s1_coef});
        rnd  = (prod + HALF) >>> FRAC_W;
        if (rnd > SMAX) begin
            sat = SMAX[DATA_W-1:0];
        end else if (rnd < SMIN) begin
            sat = SMIN[DATA_W-1:0];
        end else begin
            sat = rnd[DATA_W-1:0];
        end
        scaled = sat >>> s1_shift;
    end

    // Stage 2: register the scaled sample; hold it between pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
        end else if (load2) begin
            out_sample <= scaled;
        end
    end

    // R4: unity coefficient with no shift passes the sample through
    p_unity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load2 && s1_coef == UNITY && s1_shift == '0) |=> (out_sample == $past(s1_sample)));

    // R6: the output never takes the opposite sign to the input
    p_sign_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load2 |=> (out_sample[DATA_W-1] == $past(s1_sample[DATA_W-1])));

    // R7: the deepest coarse step leaves only 0 or -1
    p_coarse_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load2 && s1_shift == '1) |=> (out_sample == '0 || out_sample == '1));

    // R8: the output holds while no pair is delivered
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load2 |=> $stable(out_sample));

endmodule

// File: rtl/stvol_top.sv
// Module: stereo coarse/fine volume stage, top level.
// Accepts a valid-flagged left/right pair and returns the scaled pair two
// cycles later, with no backpressure. Each pair takes the register value
// present at its acceptance edge, so both channels see one setting.
module stvol_top
    import stvol_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vol_wr,
    input  logic [REG_W-1:0]           vol_wdata,
    output logic [REG_W-1:0]           vol_rdata,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);

    chan_cfg_t                cfg    [NUM_CH];
    logic signed [SAMPLE_W-1:0] smp_in  [NUM_CH];
    logic signed [SAMPLE_W-1:0] smp_out [NUM_CH];
    logic                     s1_valid;

    stvol_reg #(.NCH(NUM_CH)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (vol_wr),
        .wdata (vol_wdata),
        .rdata (vol_rdata),
        .cfg   (cfg)
    );

    // Valid pipeline matching the two datapath stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            out_valid <= s1_valid;
        end
    end

    assign smp_in[0] = in_left;
    assign smp_in[1] = in_right;
    assign out_left  = smp_out[0];
    assign out_right = smp_out[1];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        stvol_chan #(.DATA_W(SAMPLE_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .load1      (in_valid),
            .load2      (s1_valid),
            .in_sample  (smp_in[ch]),
            .cfg        (cfg[ch]),
            .out_sample (smp_out[ch])
        );
    end

    // R8: every accepted pair is delivered two cycles later
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R8: out_valid has no cause other than an accepted pair
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

endmodule

// File: tb/stvol_top_tb.sv
`timescale 1ns/1ps
// Bench: walks a vector table of settings and sample pairs, then runs
// directed tests for reset, readback, latency, hold and boundary timing.
module stvol_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vol_wr = 1'b0;
    logic [15:0] vol_wdata = '0;
    logic [15:0] vol_rdata;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_left = '0;
    logic signed [15:0] in_right = '0;
    logic        out_valid;
    logic signed [15:0] out_left;
    logic signed [15:0] out_right;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    stvol_top u_dut (
        .clk(clk), .rst_n(rst_n), .vol_wr(vol_wr), .vol_wdata(vol_wdata),
        .vol_rdata(vol_rdata), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right)
    );

    // Vectors: {volume word, left sample, right sample}
    localparam int NV = 10;
    localparam logic [47:0] VEC [NV] = '{
        {16'h0000, 16'sd1000,   -16'sd1000},   // R4 unity pass-through
        {16'hB0B0, 16'sd32767,  -16'sd32768},  // R6 clamp at both limits
        {16'h6363, 16'sd12345,  -16'sd12345},  // R4 R7 mid fine with shift
        {16'hF0D0, 16'sd10000,  -16'sd10000},  // R4 codes 15 and 13 act as 11
        {16'h0F0F, 16'sd32767,  -16'sd5},      // R7 deepest step gives 0 and -1
        {16'hA15C, 16'sd300,    -16'sd7},      // R3 R7 distinct fields per side
        {16'h2020, -16'sd3,     16'sd3},       // R5 rounding of odd samples
        {16'h0B00, 16'sd20000,  16'sd20000},   // R3 left shifted, right untouched
        {16'h1010, -16'sd1,     16'sd1},       // R5 tiny values keep sign
        {16'h5704, -16'sd20001, 16'sd31111}    // R3 R4 R7 mixed
    };

    // Expected scaled sample from the gain formula.
    function automatic logic signed [15:0] model(input logic signed [15:0] s,
                                                 input logic [3:0] fine,
                                                 input logic [3:0] coarse);
        longint c;
        longint p;
        longint q;
        int k;
        k = (fine > 4'd11) ? 11 : int'(fine);
        c = longint'($rtoi(32768.0 * (10.0 ** (real'(k) / 40.0)) + 0.5));
        p = longint'(s) * c;
        q = (p + 64'sd16384) >>> 15;
        if (q > 64'sd32767) q = 64'sd32767;
        if (q < -64'sd32768) q = -64'sd32768;
        q = q >>> coarse;
        return q[15:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag,
                     $signed(act), act, $signed(exp), exp);
        end
    endtask

    task automatic write_vol(input logic [15:0] v);
        @(negedge clk);
        vol_wr = 1'b1;
        vol_wdata = v;
        @(negedge clk);
        vol_wr = 1'b0;
    endtask

    // Present one pair, then wait to the negedge where the result is visible.
    task automatic send_pair(input logic signed [15:0] l, input logic signed [15:0] r);
        @(negedge clk);
        in_valid = 1'b1;
        in_left = l;
        in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        logic signed [15:0] l, r, hl, hr;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_left", 32'(out_left), 32'd0);
        check("R1 out_right", 32'(out_right), 32'd0);
        check("R1 vol_rdata", 32'(vol_rdata), 32'd0);
        rst_n = 1'b1;

        // R2 readback and hold
        write_vol(16'h5A3C);
        check("R2 readback", 32'(vol_rdata), 32'h5A3C);
        @(negedge clk);
        @(negedge clk);
        check("R2 hold", 32'(vol_rdata), 32'h5A3C);

        // Vector walk for R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            v = VEC[i][47:32];
            l = VEC[i][31:16];
            r = VEC[i][15:0];
            write_vol(v);
            send_pair(l, r);
            check($sformatf("R8 valid vec%0d", i), 32'(out_valid), 32'd1);
            check($sformatf("R3/R4/R5/R6/R7 left vec%0d", i), 32'(out_left),
                  32'(model(l, v[15:12], v[11:8])));
            check($sformatf("R3/R4/R5/R6/R7 right vec%0d", i), 32'(out_right),
                  32'(model(r, v[7:4], v[3:0])));
        end

        // R8 output holds and valid drops after a single pair
        hl = out_left;
        hr = out_right;
        @(negedge clk);
        check("R8 valid low", 32'(out_valid), 32'd0);
        check("R8 hold left", 32'(out_left), 32'(hl));
        check("R8 hold right", 32'(out_right), 32'(hr));

        // R9 write in the same cycle as a pair; back-to-back pairs for R8
        write_vol(16'h0000);
        @(negedge clk);
        in_valid = 1'b1;
        in_left = 16'sd4000;
        in_right = -16'sd4000;
        vol_wr = 1'b1;
        vol_wdata = 16'h0202;
        @(negedge clk);
        vol_wr = 1'b0;
        in_left = 16'sd8000;
        in_right = -16'sd8000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 first of burst valid", 32'(out_valid), 32'd1);
        check("R9 old setting left", 32'(out_left), 32'(model(16'sd4000, 4'd0, 4'd0)));
        check("R9 old setting right", 32'(out_right), 32'(model(-16'sd4000, 4'd0, 4'd0)));
        @(negedge clk);
        check("R8 second of burst valid", 32'(out_valid), 32'd1);
        check("R9 new setting left", 32'(out_left), 32'(model(16'sd8000, 4'd0, 4'd2)));
        check("R9 new setting right", 32'(out_right), 32'(model(-16'sd8000, 4'd0, 4'd2)));
        @(negedge clk);
        check("R8 burst end", 32'(out_valid), 32'd0);

        // R1 reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset rdata", 32'(vol_rdata), 32'd0);
        check("R1 reset out_left", 32'(out_left), 32'd0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule